// File: doc/BRIEF.md
# Coarse-Fine Frequency Acquisition Controller

This block is the digital control core of a two-stage frequency-locked loop in a clock recovery receiver that has no reference clock. It holds an 18-bit oscillator frequency word. It first runs a coarse search, then hands over to a fine tracking loop. Throughout, it converts the word into a 7-bit DAC code through a first-order noise-shaping truncator. Analog samplers outside the block supply a coarse "raise frequency" flag, fine up/down pulses, a strobe for each rising edge of the input data, and a strobe for each unit interval.

After reset the word sits at its lowest value, which lies below any target. In the coarse stage it climbs in equal steps for as long as the sampler says the oscillator is too slow. The word never moves down in this stage, so the loop cannot settle on a sub-harmonic. Once the raise flag has stayed low for a long unbroken run of data edges, the coarse stage ends. A fine loop then nudges the word in both directions, with a step 128 times smaller. After a long quiet run of unit intervals the block declares fine lock and enables the phase loop. The fine loop keeps correcting the word after that.

Top module: `freq_acq_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `freq_word` and `dac_code` are 0 and `coarse_lock`, `fine_lock` and `phase_en` are 0.
- R2: Before coarse lock, each cycle with both `data_rise` and `coarse_up` high adds 2048 to `freq_word`. `coarse_up` without `data_rise` changes nothing.
- R3: `coarse_lock` rises after 1024 `data_rise` strobes in a row that each see `coarse_up` low. A strobe with `coarse_up` high restarts the count, so 1023 such strobes leave `coarse_lock` at 0. Once high, `coarse_lock` stays high until reset.
- R4: After coarse lock, `data_rise` and `coarse_up` no longer move `freq_word`.
- R5: Before coarse lock, `fine_up`, `fine_dn` and `ui_tick` do not move `freq_word`.
- R6: After coarse lock, each cycle with `fine_up` high adds 16 to `freq_word`. Each cycle with `fine_dn` high subtracts 16. A cycle with both high holds the word.
- R7: After coarse lock, `fine_lock` and `phase_en` rise together after 1024 `ui_tick` strobes with neither fine pulse in between. A fine pulse restarts the count, and a fine pulse in the same cycle as a `ui_tick` wins over the tick.
- R8: After fine lock, fine pulses keep moving `freq_word` as in R6, and `fine_lock` and `phase_en` stay high until reset.
- R9: `freq_word` saturates at 262143 going up and at 0 going down; it never wraps.
- R10: Bits 17..4 of the word are kept. `dac_code` equals bits 17..11 plus a carry from a 7-bit error accumulator fed by bits 10..4. With the word held, any 128 consecutive `dac_code` values sum to bits 17..4 of the word. `dac_code` never exceeds 127 and stays at 127 when the word is at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coarse_up | input | 1 | Coarse sampler reports the oscillator is below target |
| data_rise | input | 1 | One-cycle strobe per input-data rising transition |
| ui_tick | input | 1 | One-cycle strobe per unit interval |
| fine_up | input | 1 | Fine detector: raise frequency |
| fine_dn | input | 1 | Fine detector: lower frequency |
| freq_word | output | 18 | Oscillator frequency accumulator |
| dac_code | output | 7 | Noise-shaped DAC code |
| coarse_lock | output | 1 | Coarse search finished |
| fine_lock | output | 1 | Fine loop quiet for a full run |
| phase_en | output | 1 | Enable for the phase loop |

## Verification
Two things can land in the same cycle: a fine correction and the unit-interval strobe that would advance the fine-lock run. The bench first counts 1023 quiet ticks. It then drives `ui_tick` together with `fine_up` and checks that the word moved by one fine step and that the run restarted: after 1023 further ticks no lock is reported, and one more tick brings the lock. The same collision is exercised in the coarse stage, where a strobe with `coarse_up` high both steps the word and restarts the coarse run.

// File: rtl/fa_pkg.sv
`timescale 1ns/1ps
package fa_pkg;
  typedef enum logic [1:0] {
    ST_COARSE = 2'd0,
    ST_FINE   = 2'd1,
    ST_TRACK  = 2'd2
  } acq_state_t;
endpackage

// File: rtl/fa_run_cnt.sv
`timescale 1ns/1ps
module fa_run_cnt #(
  parameter int RUN_LEN = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  input  logic clear,
  output logic done
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(RUN_LEN);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en)            cnt <= '0;
    else if (clear)            cnt <= '0;
    else if (tick && cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIMIT);

  // R3 / R7: the run count never passes its limit
  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIMIT);

  // R7: a clear in the same cycle as a tick wins
  a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (en && clear) |=> (cnt == '0));
endmodule

// File: rtl/fa_accum.sv
`timescale 1ns/1ps
module fa_accum #(
  parameter int ACC_W       = 18,
  parameter int COARSE_STEP = 2048,
  parameter int FINE_SHIFT  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up,
  input  logic             dn,
  input  logic             fine_sel,
  output logic [ACC_W-1:0] acc
);
  localparam logic [ACC_W-1:0] CSTEP = ACC_W'(COARSE_STEP);
  localparam logic [ACC_W-1:0] FSTEP = ACC_W'(COARSE_STEP >> FINE_SHIFT);
  localparam logic [ACC_W-1:0] MAXV  = {ACC_W{1'b1}};

  logic [ACC_W-1:0] step;
  logic [ACC_W:0]   sum_up;
  logic [ACC_W-1:0] nxt;

  always_comb begin
    step   = fine_sel ? FSTEP : CSTEP;
    sum_up = {1'b0, acc} + {1'b0, step};
    nxt    = acc;
    if (up && !dn) begin
      nxt = sum_up[ACC_W] ? MAXV : sum_up[ACC_W-1:0];
    end else if (dn && !up) begin
      nxt = (acc < step) ? '0 : acc - step;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= nxt;
  end

  // R9: a raise never lowers the word (no wrap at the top)
  a_r9_no_wrap_up: assert property (@(posedge clk) disable iff (rst)
    (up && !dn) |=> (acc >= $past(acc)));

  // R9: a lower never raises the word (no wrap at zero)
  a_r9_no_wrap_dn: assert property (@(posedge clk) disable iff (rst)
    (dn && !up) |=> (acc <= $past(acc)));

  // R6: opposing requests cancel
  a_r6_both_hold: assert property (@(posedge clk) disable iff (rst)
    (up && dn) |=> $stable(acc));
endmodule

// File: rtl/fa_dsm.sv
`timescale 1ns/1ps
module fa_dsm #(
  parameter int ACC_W = 18,
  parameter int DROP  = 4,
  parameter int DAC_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] word,
  output logic [DAC_W-1:0] dac
);
  localparam int RET_W  = ACC_W - DROP;
  localparam int FRAC_W = RET_W - DAC_W;

  logic [RET_W-1:0]  kept;
  logic [DAC_W-1:0]  int_part;
  logic [FRAC_W-1:0] frac, err;
  logic [FRAC_W:0]   esum;
  logic              carry;

  always_comb begin
    kept     = word[ACC_W-1:DROP];
    int_part = kept[RET_W-1:FRAC_W];
    frac     = kept[FRAC_W-1:0];
    esum     = {1'b0, err} + {1'b0, frac};
    carry    = esum[FRAC_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err <= '0;
      dac <= '0;
    end else begin
      err <= esum[FRAC_W-1:0];
      dac <= (carry && int_part != {DAC_W{1'b1}}) ? int_part + 1'b1 : int_part;
    end
  end

  // R10: output is the integer part or one above it
  a_r10_dac_near: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dac == $past(int_part) || dac == $past(int_part) + 1'b1));
endmodule

// File: rtl/freq_acq_ctrl.sv
`timescale 1ns/1ps
module freq_acq_ctrl #(
  parameter int ACC_W       = 18,
  parameter int DROP        = 4,
  parameter int DAC_W       = 7,
  parameter int COARSE_STEP = 2048,
  parameter int FINE_SHIFT  = 7,
  parameter int RUN_LEN     = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             coarse_up,
  input  logic             data_rise,
  input  logic             ui_tick,
  input  logic             fine_up,
  input  logic             fine_dn,
  output logic [ACC_W-1:0] freq_word,
  output logic [DAC_W-1:0] dac_code,
  output logic             coarse_lock,
  output logic             fine_lock,
  output logic             phase_en
);
  import fa_pkg::*;

  acq_state_t state;
  logic in_coarse, in_loop;
  logic coarse_done, fine_done;
  logic acc_up, acc_dn;
  logic fine_evt;

  always_comb begin
    in_coarse = (state == ST_COARSE);
    in_loop   = !in_coarse;
    fine_evt  = fine_up || fine_dn;
    acc_up    = in_coarse ? (data_rise && coarse_up) : fine_up;
    acc_dn    = in_coarse ? 1'b0 : fine_dn;
  end

  fa_run_cnt #(.RUN_LEN(RUN_LEN)) u_coarse_run (
    .clk  (clk),
    .rst  (rst),
    .en   (in_coarse),
    .tick (data_rise),
    .clear(data_rise && coarse_up),
    .done (coarse_done)
  );

  fa_run_cnt #(.RUN_LEN(RUN_LEN)) u_fine_run (
    .clk  (clk),
    .rst  (rst),
    .en   (state == ST_FINE),
    .tick (ui_tick),
    .clear(fine_evt),
    .done (fine_done)
  );

  fa_accum #(
    .ACC_W      (ACC_W),
    .COARSE_STEP(COARSE_STEP),
    .FINE_SHIFT (FINE_SHIFT)
  ) u_accum (
    .clk     (clk),
    .rst     (rst),
    .up      (acc_up),
    .dn      (acc_dn),
    .fine_sel(in_loop),
    .acc     (freq_word)
  );

  fa_dsm #(
    .ACC_W(ACC_W),
    .DROP (DROP),
    .DAC_W(DAC_W)
  ) u_dsm (
    .clk (clk),
    .rst (rst),
    .word(freq_word),
    .dac (dac_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_COARSE;
      coarse_lock <= 1'b0;
      fine_lock   <= 1'b0;
      phase_en    <= 1'b0;
    end else begin
      case (state)
        ST_COARSE: if (coarse_done) begin
          state       <= ST_FINE;
          coarse_lock <= 1'b1;
        end
        ST_FINE: if (fine_done) begin
          state     <= ST_TRACK;
          fine_lock <= 1'b1;
          phase_en  <= 1'b1;
        end
        default: state <= ST_TRACK;
      endcase
    end
  end

  // R3: coarse lock is sticky
  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    coarse_lock |=> coarse_lock);

  // R7: phase loop only after both locks
  a_r7_phase_after_locks: assert property (@(posedge clk) disable iff (rst)
    phase_en |-> (coarse_lock && fine_lock));

  // R8: fine lock is sticky
  a_r8_fine_sticky: assert property (@(posedge clk) disable iff (rst)
    fine_lock |=> fine_lock);

  // R5: before coarse lock only a qualified data edge moves the word
  a_r5_coarse_hold: assert property (@(posedge clk) disable iff (rst)
    (!coarse_lock && !(data_rise && coarse_up)) |=> $stable(freq_word));

  // R4: after coarse lock only fine pulses move the word
  a_r4_loop_hold: assert property (@(posedge clk) disable iff (rst)
    (coarse_lock && !fine_up && !fine_dn) |=> $stable(freq_word));
endmodule

// File: tb/freq_acq_ctrl_bench.sv
`timescale 1ns/1ps
module freq_acq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        coarse_up = 1'b0, data_rise = 1'b0, ui_tick = 1'b0;
  logic        fine_up = 1'b0, fine_dn = 1'b0;
  logic [17:0] freq_word;
  logic [6:0]  dac_code;
  logic        coarse_lock, fine_lock, phase_en;

  int errors = 0;
  int checks = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  freq_acq_ctrl u_freq_acq_ctrl (
    .clk(clk), .rst(rst), .coarse_up(coarse_up), .data_rise(data_rise),
    .ui_tick(ui_tick), .fine_up(fine_up), .fine_dn(fine_dn),
    .freq_word(freq_word), .dac_code(dac_code), .coarse_lock(coarse_lock),
    .fine_lock(fine_lock), .phase_en(phase_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; coarse_up = 0; data_rise = 0; ui_tick = 0; fine_up = 0; fine_dn = 0;
    idle(4);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic rises(input int n, input logic up);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); data_rise = 1'b1; coarse_up = up;
    end
    @(negedge clk); data_rise = 1'b0; coarse_up = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ui_tick = 1'b1;
    end
    @(negedge clk); ui_tick = 1'b0;
  endtask

  task automatic fine(input int n, input logic u, input logic d);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); fine_up = u; fine_dn = d;
    end
    @(negedge clk); fine_up = 1'b0; fine_dn = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 word in reset", freq_word, 0);
    do_reset();
    chk("R1 word", freq_word, 0);
    chk("R1 dac", dac_code, 0);
    chk("R1 flags", {coarse_lock, fine_lock, phase_en}, 0);
  endtask

  task automatic t_coarse_step();
    rises(5, 1'b1); idle(1);
    chk("R2 five coarse steps", freq_word, 5 * 2048);
    @(negedge clk); coarse_up = 1'b1; idle(4); coarse_up = 1'b0; idle(1);
    chk("R2 flag without edge", freq_word, 5 * 2048);
    fine(3, 1'b1, 1'b0); fine(2, 1'b0, 1'b1); ticks(5); idle(1);
    chk("R5 fine pulses ignored in coarse", freq_word, 5 * 2048);
  endtask

  task automatic t_coarse_lock();
    rises(1000, 1'b0);
    rises(1, 1'b1);
    rises(1023, 1'b0); idle(3);
    chk("R3 no lock after 1023", coarse_lock, 0);
    chk("R2 restart edge stepped", freq_word, 6 * 2048);
    rises(1, 1'b0); idle(2);
    chk("R3 lock after 1024", coarse_lock, 1);
    chk("R7 no fine lock yet", {fine_lock, phase_en}, 0);
    rises(3, 1'b1); idle(1);
    chk("R4 coarse frozen", freq_word, 6 * 2048);
  endtask

  task automatic t_fine_step();
    fine(1, 1'b1, 1'b0); idle(1);
    chk("R6 fine up", freq_word, 12288 + 16);
    fine(2, 1'b0, 1'b1); idle(1);
    chk("R6 fine down", freq_word, 12288 - 16);
    fine(3, 1'b1, 1'b1); idle(1);
    chk("R6 both hold", freq_word, 12288 - 16);
    fine(4, 1'b1, 1'b0); idle(1);
    chk("R6 net word", freq_word, 12336);
  endtask

  task automatic t_dac();
    int sum = 0;
    int bad = 0;
    idle(4);
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      sum += dac_code;
      if (dac_code != 6 && dac_code != 7) bad++;
    end
    chk("R10 dac average", sum, 12336 >> 4);
    chk("R10 dac range", bad, 0);
  endtask

  task automatic t_fine_lock();
    ticks(1023);
    @(negedge clk); ui_tick = 1'b1; fine_up = 1'b1;
    @(negedge clk); ui_tick = 1'b0; fine_up = 1'b0;
    idle(1);
    chk("R7 collision word", freq_word, 12352);
    ticks(1023); idle(3);
    chk("R7 no lock after restart", fine_lock, 0);
    ticks(1); idle(2);
    chk("R7 fine lock", fine_lock, 1);
    chk("R7 phase enable", phase_en, 1);
    fine(1, 1'b0, 1'b1); idle(2);
    chk("R8 tracking continues", freq_word, 12336);
    chk("R8 lock held", {fine_lock, phase_en}, 3);
  endtask

  task automatic t_sat_hi();
    int bad = 0;
    do_reset();
    rises(130, 1'b1); idle(4);
    chk("R9 top saturation", freq_word, 262143);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (dac_code != 127) bad++;
    end
    chk("R10 dac pinned at 127", bad, 0);
  endtask

  task automatic t_sat_lo();
    do_reset();
    rises(1024, 1'b0); idle(2);
    chk("R3 immediate lock", coarse_lock, 1);
    fine(3, 1'b0, 1'b1); idle(2);
    chk("R9 bottom saturation", freq_word, 0);
    chk("R10 dac at zero", dac_code, 0);
  endtask

  initial begin
    t_reset();
    t_coarse_step();
    t_coarse_lock();
    t_fine_step();
    t_dac();
    t_fine_lock();
    t_sat_hi();
    t_sat_lo();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule